// File: doc/BRIEF.md
# Next-PC and Link Unit

This block owns the program counter of a small 32-bit load/store core and decides, once per advancing cycle, which address the core fetches next. The decoder hands it a compact flow-control code together with the immediate fields of the current instruction and the two register operands. From these the block picks one of five outcomes. It can step to the next word. It can take a conditional relative branch on equality or inequality. It can make a region-relative absolute jump, a jump that also records a return address, or a jump through a register value.

The return address leaves the block as a one-cycle write request aimed at a fixed link register, and that request is the only path from program-counter state into the register file. A register-indirect target whose low two bits are not zero does not move the PC. Instead it raises a one-cycle misaligned-fetch flag, so that trap logic elsewhere can respond.

Top module: `npc_unit`

## Requirements
- R1: While reset (rst_n low) is held, pc_o is 0x00000000 and both link_we_o and misalign_o are 0.
- R2: In a cycle where adv_en is low, pc_o, link_we_o=0 and misalign_o=0 hold after the clock edge, whatever op_i says.
- R3: With op_i=0 (step), and for any unused code 6 or 7, an advance sets pc_o to pc_o+4.
- R4: With op_i=1 (branch if equal) and opa_i==opb_i, the new PC is PC+4+(sign-extended imm_i × 4), and backward offsets are allowed. If the operands differ, the new PC is PC+4.
- R5: With op_i=2 (branch if not equal) and opa_i!=opb_i, the new PC is PC+4+(sign-extended imm_i × 4). If the operands are equal, the new PC is PC+4.
- R6: With op_i=3 (jump), the new PC is bits 31:28 of PC+4, followed by jidx_i, followed by two zero bits.
- R7: With op_i=4 (jump and link), the PC moves as in R6. In the cycle after the edge, link_we_o is 1 for exactly one cycle and link_data_o equals the old PC+4.
- R8: link_idx_o is always 31.
- R9: With op_i=5 (jump register) and opa_i[1:0]==0, the new PC is opa_i.
- R10: With op_i=5 and opa_i[1:0]!=0, pc_o is unchanged and misalign_o is 1 for the cycle after the edge. Otherwise misalign_o is 0.
- R11: link_we_o is raised only by code 4. Jump register and all other codes leave it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_en | input | 1 | Advance the PC this cycle |
| op_i | input | 3 | Flow code: 0 step, 1 beq, 2 bne, 3 jump, 4 jump-link, 5 jump-register |
| imm_i | input | 16 | Signed branch offset in words |
| jidx_i | input | 26 | Jump word-index field |
| opa_i | input | 32 | First register operand, also the jump-register target |
| opb_i | input | 32 | Second register operand |
| pc_o | output | 32 | Current program counter |
| link_we_o | output | 1 | Link-register write request |
| link_data_o | output | 32 | Return address to write |
| link_idx_o | output | 5 | Link register index |
| misalign_o | output | 1 | Misaligned jump-register target flag |

## Verification
The embedded properties check the following on every cycle:
- the PC holds when the advance is low;
- the PC steps by four on a plain advance;
- a link request follows every jump-and-link, carrying the return address;
- a misaligned flag always coincides with an unchanged PC;
- the PC stays word aligned.

Only the directed scenarios can show that the branch offset arithmetic is right in both directions, and that the jump region bits are drawn from PC+4 rather than from the PC. They also show that both branch codes fall through correctly on the opposite comparison.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      FLOW_SEQ = 3'd0,
      FLOW_BEQ = 3'd1,
      FLOW_BNE = 3'd2,
      FLOW_JMP = 3'd3,
      FLOW_JAL = 3'd4,
      FLOW_JR  = 3'd5
   } flow_op_e;
endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16,
   parameter int JIDX_W = 26
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [JIDX_W-1:0] jidx_i,
   output logic [ADDR_W-1:0] seq_o,
   output logic [ADDR_W-1:0] br_o,
   output logic [ADDR_W-1:0] jmp_o
);
   localparam int EXT_W = ADDR_W - IMM_W - 2;
   localparam int REG_W = ADDR_W - JIDX_W - 2;

   generate
      if (EXT_W < 0) begin : g_bad_imm
         $error("npc_target_gen: IMM_W too wide for ADDR_W");
      end
      if (REG_W < 1) begin : g_bad_jidx
         $error("npc_target_gen: JIDX_W leaves no region bits");
      end
   endgenerate

   logic [ADDR_W-1:0] offs;

   always_comb begin
      seq_o = pc_i + ADDR_W'(4);
      offs  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
      br_o  = seq_o + offs;
      jmp_o = {seq_o[ADDR_W-1 -: REG_W], jidx_i, 2'b00};
   end
endmodule

// File: rtl/npc_operand_cmp.sv
module npc_operand_cmp #(
   parameter int W    = 32,
   parameter int IMPL = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         eq_o
);
   generate
      if (IMPL == 0) begin : g_direct
         assign eq_o = (a_i == b_i);
      end else if (IMPL == 1) begin : g_xor_tree
         logic [W-1:0] diff;
         assign diff = a_i ^ b_i;
         assign eq_o = ~|diff;
      end else begin : g_bad
         $error("npc_operand_cmp: IMPL must be 0 or 1");
         assign eq_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/npc_next_sel.sv
module npc_next_sel
   import npc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  flow_op_e          op_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] seq_i,
   input  logic [ADDR_W-1:0] br_i,
   input  logic [ADDR_W-1:0] jmp_i,
   input  logic [ADDR_W-1:0] reg_tgt_i,
   input  logic              eq_i,
   output logic [ADDR_W-1:0] next_o,
   output logic              misal_o,
   output logic              link_req_o
);
   always_comb begin
      next_o     = seq_i;
      misal_o    = 1'b0;
      link_req_o = 1'b0;
      unique case (op_i)
         FLOW_BEQ: next_o = eq_i ? br_i : seq_i;
         FLOW_BNE: next_o = eq_i ? seq_i : br_i;
         FLOW_JMP: next_o = jmp_i;
         FLOW_JAL: begin
            next_o     = jmp_i;
            link_req_o = 1'b1;
         end
         FLOW_JR: begin
            if (reg_tgt_i[1:0] != 2'b00) begin
               next_o  = pc_i;
               misal_o = 1'b1;
            end else begin
               next_o = reg_tgt_i;
            end
         end
         default: next_o = seq_i;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          IMM_W     = 16,
   parameter int          JIDX_W    = 26,
   parameter int          REG_IDX_W = 5,
   parameter int          LINK_REG  = 31,
   parameter logic [31:0] RESET_PC  = 32'h0000_0000,
   parameter int          CMP_IMPL  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv_en,
   input  logic [2:0]           op_i,
   input  logic [IMM_W-1:0]     imm_i,
   input  logic [JIDX_W-1:0]    jidx_i,
   input  logic [ADDR_W-1:0]    opa_i,
   input  logic [ADDR_W-1:0]    opb_i,
   output logic [ADDR_W-1:0]    pc_o,
   output logic                 link_we_o,
   output logic [ADDR_W-1:0]    link_data_o,
   output logic [REG_IDX_W-1:0] link_idx_o,
   output logic                 misalign_o
);
   localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

   generate
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
         $error("npc_unit: RESET_PC must be word aligned");
      end
      if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
         $error("npc_unit: LINK_REG does not fit REG_IDX_W");
      end
   endgenerate

   flow_op_e          op;
   logic [ADDR_W-1:0] seq_t, br_t, jmp_t, next_pc;
   logic              eq, misal_c, link_req;

   assign op = flow_op_e'(op_i);

   npc_target_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
      .pc_i  (pc_o),
      .imm_i (imm_i),
      .jidx_i(jidx_i),
      .seq_o (seq_t),
      .br_o  (br_t),
      .jmp_o (jmp_t)
   );

   npc_operand_cmp #(.W(ADDR_W), .IMPL(CMP_IMPL)) u_cmp (
      .a_i (opa_i),
      .b_i (opb_i),
      .eq_o(eq)
   );

   npc_next_sel #(.ADDR_W(ADDR_W)) u_sel (
      .op_i      (op),
      .pc_i      (pc_o),
      .seq_i     (seq_t),
      .br_i      (br_t),
      .jmp_i     (jmp_t),
      .reg_tgt_i (opa_i),
      .eq_i      (eq),
      .next_o    (next_pc),
      .misal_o   (misal_c),
      .link_req_o(link_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o        <= PC_INIT;
         link_we_o   <= 1'b0;
         link_data_o <= '0;
         misalign_o  <= 1'b0;
      end else begin
         link_we_o  <= adv_en & link_req;
         misalign_o <= adv_en & misal_c;
         if (adv_en) begin
            pc_o <= next_pc;
            if (link_req) link_data_o <= seq_t;
         end
      end
   end

   assign link_idx_o = REG_IDX_W'(LINK_REG);

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> ($stable(pc_o) && !link_we_o && !misalign_o));

   // R3
   step_by_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && op_i == 3'd0) |=> (pc_o == $past(pc_o) + ADDR_W'(4)));

   // R7
   link_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && op_i == 3'd4) |=> (link_we_o && link_data_o == $past(pc_o) + ADDR_W'(4)));

   // R10
   misalign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      misalign_o |-> (pc_o == $past(pc_o)));

   // R9
   pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_o[1:0] == 2'b00);
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        adv_en;
   logic [2:0]  op_i;
   logic [15:0] imm_i;
   logic [25:0] jidx_i;
   logic [31:0] opa_i, opb_i;
   logic [31:0] pc_o, link_data_o;
   logic        link_we_o, misalign_o;
   logic [4:0]  link_idx_o;

   int tests = 0;
   int fails = 0;
   logic [31:0] exp_pc;

   always #10 clk = ~clk;

   npc_unit u_npc_unit (
      .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .op_i(op_i), .imm_i(imm_i),
      .jidx_i(jidx_i), .opa_i(opa_i), .opb_i(opb_i), .pc_o(pc_o),
      .link_we_o(link_we_o), .link_data_o(link_data_o), .link_idx_o(link_idx_o),
      .misalign_o(misalign_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic en, input logic [2:0] op, input logic [15:0] imm,
                        input logic [25:0] jidx, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      adv_en = en; op_i = op; imm_i = imm; jidx_i = jidx; opa_i = a; opb_i = b;
      @(negedge clk);
      adv_en = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; adv_en = 1'b1; op_i = 3'd4; imm_i = '0; jidx_i = 26'h10; opa_i = '0; opb_i = '0;
      repeat (3) @(negedge clk);
      chk("R1 pc", pc_o, 32'h0);
      chk("R1 link_we", {31'b0, link_we_o}, 32'h0);
      chk("R1 misalign", {31'b0, misalign_o}, 32'h0);
      adv_en = 1'b0; rst_n = 1'b1;
      exp_pc = 32'h0;
   endtask

   task automatic t_step();
      drive(1, 3'd0, 16'h0, 26'h0, 0, 0); exp_pc += 4;
      chk("R3 step", pc_o, exp_pc);
      drive(1, 3'd7, 16'h0, 26'h0, 0, 0); exp_pc += 4;
      chk("R3 unused code", pc_o, exp_pc);
      chk("R11 no link on step", {31'b0, link_we_o}, 32'h0);
   endtask

   task automatic t_hold();
      drive(0, 3'd4, 16'h0, 26'h100, 0, 0);
      chk("R2 hold pc", pc_o, exp_pc);
      chk("R2 no link", {31'b0, link_we_o}, 32'h0);
   endtask

   task automatic t_branch();
      drive(1, 3'd1, 16'd3, 26'h0, 32'h55, 32'h55); exp_pc = exp_pc + 4 + 12;
      chk("R4 beq taken", pc_o, exp_pc);
      drive(1, 3'd1, 16'd3, 26'h0, 32'h55, 32'h56); exp_pc += 4;
      chk("R4 beq not taken", pc_o, exp_pc);
      drive(1, 3'd2, 16'hFFFE, 26'h0, 32'h1, 32'h2); exp_pc = exp_pc + 4 - 8;
      chk("R5 bne taken backward", pc_o, exp_pc);
      drive(1, 3'd2, 16'hFFFE, 26'h0, 32'h7, 32'h7); exp_pc += 4;
      chk("R5 bne not taken", pc_o, exp_pc);
   endtask

   task automatic t_jumps();
      drive(1, 3'd3, 16'h0, 26'h100, 0, 0); exp_pc = 32'h400;
      chk("R6 jump", pc_o, exp_pc);
      drive(1, 3'd5, 16'h0, 26'h0, 32'hF000_0010, 0); exp_pc = 32'hF000_0010;
      chk("R9 jr", pc_o, exp_pc);
      chk("R11 no link on jr", {31'b0, link_we_o}, 32'h0);
      drive(1, 3'd3, 16'h0, 26'h40, 0, 0); exp_pc = 32'hF000_0100;
      chk("R6 region bits kept", pc_o, exp_pc);
   endtask

   task automatic t_link();
      logic [31:0] ret;
      ret = exp_pc + 4;
      drive(1, 3'd4, 16'h0, 26'h20, 0, 0); exp_pc = 32'hF000_0080;
      chk("R7 jal target", pc_o, exp_pc);
      chk("R7 link_we", {31'b0, link_we_o}, 32'h1);
      chk("R7 link data", link_data_o, ret);
      chk("R8 link idx", {27'b0, link_idx_o}, 32'd31);
      drive(1, 3'd0, 16'h0, 26'h0, 0, 0); exp_pc += 4;
      chk("R7 link one cycle", {31'b0, link_we_o}, 32'h0);
   endtask

   task automatic t_misalign();
      drive(1, 3'd5, 16'h0, 26'h0, 32'h0000_1002, 0);
      chk("R10 pc unchanged", pc_o, exp_pc);
      chk("R10 flag", {31'b0, misalign_o}, 32'h1);
      drive(1, 3'd0, 16'h0, 26'h0, 0, 0); exp_pc += 4;
      chk("R10 flag clears", {31'b0, misalign_o}, 32'h0);
      chk("R3 step after flag", pc_o, exp_pc);
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_step();
      t_hold();
      t_branch();
      t_jumps();
      t_link();
      t_misalign();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule